// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the data half of a 32-bit load/store processor that runs each instruction over several clock cycles. One memory port carries both instruction fetches and data accesses. One ALU does all the arithmetic: the program-counter increment, the branch-target sum, address generation and register-to-register operations. Holding registers between the functional units carry each partial result into the next cycle. These are the instruction register, the memory data register, the two operand latches and the ALU result latch.

An external sequencer drives a set of steering and enable inputs every cycle. The datapath returns the opcode and function fields of the current instruction to it. The block holds the program counter, a 32-entry general register file, sign extension, the word-offset shift, every steering multiplexer and a small map from a 2-bit ALU mode to the ALU operation. Memory is assumed to return read data in the same cycle the address is presented, and to commit a write on the clock edge.

Top module: `mc_datapath`

## Requirements
- R1: An asynchronous reset (rst_n low) clears the program counter to 0, so the first fetch after release presents address 0.
- R2: The instruction register loads mem_rdata only in cycles with ctl_ir_wr high. At other times it holds, so opcode and funct keep their values across data-memory reads.
- R3: The memory data register, both operand latches and the ALU result latch load on every clock edge with no enable. A word read in one cycle is therefore available for register write-back in the next.
- R4: mem_addr is the program counter when ctl_addr_from_alu=0, and the ALU result latch when it is 1.
- R5: The first ALU operand is the program counter when ctl_srca_reg=0, and the first operand latch when it is 1. The second operand is chosen by ctl_srcb_sel: 00 the second operand latch, 01 the constant 4, 10 the sign-extended IR[15:0], 11 the sign-extended IR[15:0] shifted left by two.
- R6: The program counter is written when ctl_pc_wr=1, or when ctl_pc_wr_cond=1 and the ALU result is zero. Otherwise it holds.
- R7: The next program counter is chosen by ctl_pc_src: 00 the live ALU result, 01 the ALU result latch, 10 the jump target {PC[31:28], IR[25:0], 00}.
- R8: A register-file write (ctl_rf_wr=1) goes to IR[15:11] when ctl_dst_rd=1 and to IR[20:16] when it is 0. The data is the ALU result latch when ctl_wb_mem=0 and the memory data register when it is 1. The read addresses are IR[25:21] and IR[20:16].
- R9: Register 0 always reads as zero, and writes to it have no effect.
- R10: ALU mode 00 adds and mode 01 subtracts. Mode 10 decodes funct: 100000 add, 100010 subtract, 100100 and, 100101 or, 101010 signed set-less-than (result 1 or 0). Any other funct gives add.
- R11: opcode is IR[31:26] and funct is IR[5:0].
- R12: mem_rd and mem_wr follow ctl_mem_rd and ctl_mem_wr in the same cycle, and mem_wdata is the second operand latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_pc_wr | input | 1 | Unconditional program-counter write |
| ctl_pc_wr_cond | input | 1 | Program-counter write when the ALU result is zero |
| ctl_addr_from_alu | input | 1 | Memory address from the ALU result latch (1) or the program counter (0) |
| ctl_ir_wr | input | 1 | Instruction register load enable |
| ctl_rf_wr | input | 1 | Register-file write enable |
| ctl_dst_rd | input | 1 | Write destination IR[15:11] (1) or IR[20:16] (0) |
| ctl_wb_mem | input | 1 | Write-back data from the memory data register (1) or the ALU result latch (0) |
| ctl_srca_reg | input | 1 | First ALU operand from the operand latch (1) or the program counter (0) |
| ctl_srcb_sel | input | 2 | Second ALU operand select |
| ctl_pc_src | input | 2 | Next program-counter select |
| ctl_alu_op | input | 2 | ALU mode |
| ctl_mem_rd | input | 1 | Memory read request |
| ctl_mem_wr | input | 1 | Memory write request |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| opcode | output | 6 | Instruction bits 31:26 |
| funct | output | 6 | Instruction bits 5:0 |

## Verification
The bench acts as the sequencer and steps loads, stores, register-to-register operations, taken and untaken branches and a jump through their cycles. One scenario reads data memory after the fetch. If the instruction register reloaded there, the opcode would change in the middle of the instruction. Other corner cases are a store with a negative offset, a signed compare on a negative operand, a write to register 0 and a funct value that is not decoded. A design that got these wrong would show a wrong address, zero-extend the offset, compare unsigned, hand back a stale nonzero register 0, or give the undecoded funct some operation other than add. After a branch or jump the next fetch address is compared, which exposes a wrong PC write condition or a wrong PC source.

// File: rtl/mc_dp_pkg.sv
package mc_dp_pkg;

  typedef enum logic [2:0] {
    FN_ADD = 3'd0,
    FN_SUB = 3'd1,
    FN_AND = 3'd2,
    FN_OR  = 3'd3,
    FN_SLT = 3'd4
  } alu_fn_e;

  localparam logic [1:0] MODE_ADD   = 2'b00;
  localparam logic [1:0] MODE_SUB   = 2'b01;
  localparam logic [1:0] MODE_FUNCT = 2'b10;

  localparam logic [5:0] FC_ADD = 6'b100000;
  localparam logic [5:0] FC_SUB = 6'b100010;
  localparam logic [5:0] FC_AND = 6'b100100;
  localparam logic [5:0] FC_OR  = 6'b100101;
  localparam logic [5:0] FC_SLT = 6'b101010;

  localparam logic [1:0] OPB_REG  = 2'b00;
  localparam logic [1:0] OPB_FOUR = 2'b01;
  localparam logic [1:0] OPB_IMM  = 2'b10;
  localparam logic [1:0] OPB_OFS  = 2'b11;

  localparam logic [1:0] NPC_ALU   = 2'b00;
  localparam logic [1:0] NPC_LATCH = 2'b01;
  localparam logic [1:0] NPC_JUMP  = 2'b10;

endpackage

// File: rtl/mc_alu_ctrl.sv
module mc_alu_ctrl
  import mc_dp_pkg::*;
(
  input  logic [1:0] mode,
  input  logic [5:0] fcode,
  output alu_fn_e    fn
);

  // R10: mode and function-code decode
  always_comb begin
    fn = FN_ADD;
    unique case (mode)
      MODE_SUB:   fn = FN_SUB;
      MODE_FUNCT: begin
        case (fcode)
          FC_SUB:  fn = FN_SUB;
          FC_AND:  fn = FN_AND;
          FC_OR:   fn = FN_OR;
          FC_SLT:  fn = FN_SLT;
          default: fn = FN_ADD;
        endcase
      end
      default:    fn = FN_ADD;
    endcase
  end

endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_dp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  alu_fn_e      fn,
  output logic [W-1:0] res,
  output logic         is_zero
);

  logic [W-1:0] diff;
  logic         lt;

  assign diff = opa - opb;
  assign lt   = $signed(opa) < $signed(opb);

  always_comb begin
    res = opa + opb;
    case (fn)
      FN_SUB:  res = diff;
      FN_AND:  res = opa & opb;
      FN_OR:   res = opa | opb;
      FN_SLT:  res = {{(W-1){1'b0}}, lt};
      default: res = opa + opb;
    endcase
  end

  assign is_zero = (res == '0);

  // R10: a subtract result flags zero exactly when the operands match
  a_r10_sub_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == FN_SUB) |-> (is_zero == (opa == opb)));

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] regs_q [DEPTH];

  // entry 0 is never stored; R9
  generate
    for (genvar gi = 1; gi < DEPTH; gi++) begin : g_row
      always_ff @(posedge clk) begin
        if (we && (wa == AW'(gi))) regs_q[gi] <= wd;
      end
    end
  endgenerate

  always_ff @(posedge clk) regs_q[0] <= '0;

  assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];

  // R8: a write to a nonzero entry is visible in that entry next cycle
  a_r8_rf_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (wa != '0)) |=> (regs_q[$past(wa)] == $past(wd)));

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_dp_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int RF_AW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_pc_wr,
  input  logic            ctl_pc_wr_cond,
  input  logic            ctl_addr_from_alu,
  input  logic            ctl_ir_wr,
  input  logic            ctl_rf_wr,
  input  logic            ctl_dst_rd,
  input  logic            ctl_wb_mem,
  input  logic            ctl_srca_reg,
  input  logic [1:0]      ctl_srcb_sel,
  input  logic [1:0]      ctl_pc_src,
  input  logic [1:0]      ctl_alu_op,
  input  logic            ctl_mem_rd,
  input  logic            ctl_mem_wr,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [5:0]      opcode,
  output logic [5:0]      funct
);

  localparam int IMM_W = 16;
  localparam int JMP_W = 26;
  localparam int EXT_W = XLEN - IMM_W;
  localparam int PCH_W = XLEN - JMP_W - 2;

  // architectural and holding registers
  logic [XLEN-1:0] pc_q, pc_d;
  logic [XLEN-1:0] ir_q, ir_d;
  logic [XLEN-1:0] mdr_q, opa_q, opb_q, res_q;

  logic [XLEN-1:0] rf_rd1, rf_rd2, rf_wd;
  logic [RF_AW-1:0] rf_wa;
  logic [XLEN-1:0] imm_sx, imm_ofs, jmp_tgt;
  logic [XLEN-1:0] alu_a, alu_b, alu_y;
  logic            alu_z;
  logic            pc_en;
  alu_fn_e         alu_fn;

  // field extraction
  assign opcode  = ir_q[31:26];
  assign funct   = ir_q[5:0];
  assign imm_sx  = {{EXT_W{ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign imm_ofs = {imm_sx[XLEN-3:0], 2'b00};
  assign jmp_tgt = {pc_q[XLEN-1 -: PCH_W], ir_q[JMP_W-1:0], 2'b00};

  // memory port
  assign mem_addr  = ctl_addr_from_alu ? res_q : pc_q;
  assign mem_wdata = opb_q;
  assign mem_rd    = ctl_mem_rd;
  assign mem_wr    = ctl_mem_wr;

  // register file steering
  assign rf_wa = ctl_dst_rd ? RF_AW'(ir_q[15:11]) : RF_AW'(ir_q[20:16]);
  assign rf_wd = ctl_wb_mem ? mdr_q : res_q;

  mc_regfile #(.W(XLEN), .AW(RF_AW)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .ra1   (RF_AW'(ir_q[25:21])),
    .ra2   (RF_AW'(ir_q[20:16])),
    .rd1   (rf_rd1),
    .rd2   (rf_rd2),
    .we    (ctl_rf_wr),
    .wa    (rf_wa),
    .wd    (rf_wd)
  );

  // ALU operand steering
  assign alu_a = ctl_srca_reg ? opa_q : pc_q;

  always_comb begin
    alu_b = opb_q;
    case (ctl_srcb_sel)
      OPB_FOUR: alu_b = XLEN'(4);
      OPB_IMM:  alu_b = imm_sx;
      OPB_OFS:  alu_b = imm_ofs;
      default:  alu_b = opb_q;
    endcase
  end

  mc_alu_ctrl u_actl (
    .mode  (ctl_alu_op),
    .fcode (funct),
    .fn    (alu_fn)
  );

  mc_alu #(.W(XLEN)) u_alu (
    .clk     (clk),
    .rst_n   (rst_n),
    .opa     (alu_a),
    .opb     (alu_b),
    .fn      (alu_fn),
    .res     (alu_y),
    .is_zero (alu_z)
  );

  // next-state logic
  assign pc_en = ctl_pc_wr | (ctl_pc_wr_cond & alu_z);

  always_comb begin
    pc_d = pc_q;
    if (pc_en) begin
      case (ctl_pc_src)
        NPC_LATCH: pc_d = res_q;
        NPC_JUMP:  pc_d = jmp_tgt;
        default:   pc_d = alu_y;
      endcase
    end
    ir_d = ctl_ir_wr ? mem_rdata : ir_q;
  end

  // registers with reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      ir_q <= '0;
    end else begin
      pc_q <= pc_d;
      ir_q <= ir_d;
    end
  end

  // holding registers, loaded every edge
  always_ff @(posedge clk) begin
    mdr_q <= mem_rdata;
    opa_q <= rf_rd1;
    opb_q <= rf_rd2;
    res_q <= alu_y;
  end

  // R1: program counter is zero on the first edge after reset release
  a_r1_pc_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pc_q == '0));

  // R2: instruction register holds without its enable
  a_r2_ir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_ir_wr |=> $stable(ir_q));

  // R3: holding registers capture on every edge
  a_r3_mdr_follow: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (mdr_q == $past(mem_rdata)));

  a_r3_res_follow: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (res_q == $past(alu_y)));

  // R6: no write request and no qualified condition keeps the PC
  a_r6_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_pc_wr && !(ctl_pc_wr_cond && alu_z)) |=> $stable(pc_q));

endmodule

// File: tb/mc_datapath_tb.sv
module mc_datapath_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        ctl_pc_wr, ctl_pc_wr_cond, ctl_addr_from_alu, ctl_ir_wr;
  logic        ctl_rf_wr, ctl_dst_rd, ctl_wb_mem, ctl_srca_reg;
  logic [1:0]  ctl_srcb_sel, ctl_pc_src, ctl_alu_op;
  logic        ctl_mem_rd, ctl_mem_wr;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr;
  logic [5:0]  opcode, funct;

  logic [31:0] mem [64];
  logic [31:0] exp_pc;
  int          n_chk;
  int          n_bad;
  bit          done;

  mc_datapath u_dut (
    .clk               (clk),
    .rst_n             (rst_n),
    .ctl_pc_wr         (ctl_pc_wr),
    .ctl_pc_wr_cond    (ctl_pc_wr_cond),
    .ctl_addr_from_alu (ctl_addr_from_alu),
    .ctl_ir_wr         (ctl_ir_wr),
    .ctl_rf_wr         (ctl_rf_wr),
    .ctl_dst_rd        (ctl_dst_rd),
    .ctl_wb_mem        (ctl_wb_mem),
    .ctl_srca_reg      (ctl_srca_reg),
    .ctl_srcb_sel      (ctl_srcb_sel),
    .ctl_pc_src        (ctl_pc_src),
    .ctl_alu_op        (ctl_alu_op),
    .ctl_mem_rd        (ctl_mem_rd),
    .ctl_mem_wr        (ctl_mem_wr),
    .mem_addr          (mem_addr),
    .mem_wdata         (mem_wdata),
    .mem_rdata         (mem_rdata),
    .mem_rd            (mem_rd),
    .mem_wr            (mem_wr),
    .opcode            (opcode),
    .funct             (funct)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: same-cycle read, write on the edge
  assign mem_rdata = mem[mem_addr[7:2]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[7:2]] <= mem_wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clr_ctl();
    ctl_pc_wr = 0; ctl_pc_wr_cond = 0; ctl_addr_from_alu = 0; ctl_ir_wr = 0;
    ctl_rf_wr = 0; ctl_dst_rd = 0; ctl_wb_mem = 0; ctl_srca_reg = 0;
    ctl_srcb_sel = 2'b00; ctl_pc_src = 2'b00; ctl_alu_op = 2'b00;
    ctl_mem_rd = 0; ctl_mem_wr = 0;
  endtask

  function automatic logic [31:0] enc_r(input int rs, rt, rd, input logic [5:0] fc);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fc};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, rt,
                                        input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  // fetch and decode, common to every instruction
  task automatic fetch_decode(input logic [31:0] instr);
    mem[exp_pc[7:2]] = instr;
    @(negedge clk); clr_ctl();
    ctl_mem_rd = 1; ctl_ir_wr = 1; ctl_srcb_sel = 2'b01; ctl_pc_wr = 1;
    #1 chk("R4 fetch address from PC", mem_addr, exp_pc);
    chk("R12 read strobe", {31'd0, mem_rd}, 32'd1);
    exp_pc = exp_pc + 4;
    @(negedge clk); clr_ctl();
    ctl_srcb_sel = 2'b11;
    #1 chk("R11 opcode", {26'd0, opcode}, {26'd0, instr[31:26]});
    chk("R11 funct", {26'd0, funct}, {26'd0, instr[5:0]});
  endtask

  task automatic do_rtype(input int rs, rt, rd, input logic [5:0] fc);
    fetch_decode(enc_r(rs, rt, rd, fc));
    @(negedge clk); clr_ctl();
    ctl_srca_reg = 1; ctl_alu_op = 2'b10;
    @(negedge clk); clr_ctl();
    ctl_dst_rd = 1; ctl_rf_wr = 1;
  endtask

  task automatic do_load(input int base, rt, input logic [15:0] imm, input logic [31:0] ea);
    fetch_decode(enc_i(6'd35, base, rt, imm));
    @(negedge clk); clr_ctl();
    ctl_srca_reg = 1; ctl_srcb_sel = 2'b10;
    @(negedge clk); clr_ctl();
    ctl_addr_from_alu = 1; ctl_mem_rd = 1;
    #1 chk("R4 load address from ALU latch", mem_addr, ea);
    @(negedge clk); clr_ctl();
    ctl_wb_mem = 1; ctl_rf_wr = 1;
    #1 chk("R2 opcode held after data read", {26'd0, opcode}, 32'd35);
  endtask

  task automatic do_store(input int base, rt, input logic [15:0] imm,
                          input logic [31:0] ea, input logic [31:0] val, input string req);
    fetch_decode(enc_i(6'd43, base, rt, imm));
    @(negedge clk); clr_ctl();
    ctl_srca_reg = 1; ctl_srcb_sel = 2'b10;
    @(negedge clk); clr_ctl();
    ctl_addr_from_alu = 1; ctl_mem_wr = 1;
    #1 chk("R5 store address", mem_addr, ea);
    chk(req, mem_wdata, val);
    chk("R12 write strobe", {30'd0, mem_wr, mem_rd}, 32'd2);
    @(negedge clk); clr_ctl();
    #1 chk("R12 store committed", mem[ea[7:2]], val);
  endtask

  task automatic do_beq(input int rs, rt, input logic [15:0] imm);
    fetch_decode(enc_i(6'd4, rs, rt, imm));
    @(negedge clk); clr_ctl();
    ctl_srca_reg = 1; ctl_alu_op = 2'b01; ctl_pc_src = 2'b01; ctl_pc_wr_cond = 1;
  endtask

  task automatic do_jump(input logic [25:0] tgt);
    fetch_decode({6'd2, tgt});
    @(negedge clk); clr_ctl();
    ctl_pc_src = 2'b10; ctl_pc_wr = 1;
  endtask

  task automatic t_reset();
    @(negedge clk); clr_ctl();
    #1 chk("R1 reset PC", mem_addr, 32'd0);
    chk("R2 reset IR opcode", {26'd0, opcode}, 32'd0);
  endtask

  task automatic t_loads_stores();
    do_load(0, 1, 16'd128, 32'd128);
    do_load(0, 2, 16'd132, 32'd132);
    do_load(0, 3, 16'd136, 32'd136);
    do_load(0, 10, 16'd140, 32'd140);
    do_store(0, 1, 16'd144, 32'd144, 32'h1234_5678, "R3 R8 loaded word reaches register");
  endtask

  task automatic t_alu_ops();
    do_rtype(2, 3, 4, 6'b100000);
    do_store(0, 4, 16'd148, 32'd148, 32'hFFFF_FFF5, "R10 add");
    do_rtype(3, 2, 5, 6'b100010);
    do_store(0, 5, 16'd152, 32'd152, 32'd21, "R10 sub");
    do_rtype(1, 2, 6, 6'b100100);
    do_store(0, 6, 16'd156, 32'd156, 32'h1234_5670, "R10 and");
    do_rtype(1, 3, 7, 6'b100101);
    do_store(0, 7, 16'd160, 32'd160, 32'h1234_567D, "R10 or");
    do_rtype(2, 3, 8, 6'b101010);
    do_store(0, 8, 16'd164, 32'd164, 32'd1, "R10 slt signed negative less");
    do_rtype(3, 2, 9, 6'b101010);
    do_store(0, 9, 16'd168, 32'd168, 32'd0, "R10 slt signed not less");
    do_rtype(1, 3, 11, 6'b100111);
    do_store(0, 11, 16'd172, 32'd172, 32'h1234_567D, "R10 undecoded funct adds");
  endtask

  task automatic t_reg_zero();
    do_rtype(1, 3, 0, 6'b100000);
    do_store(0, 0, 16'd176, 32'd176, 32'd0, "R9 register 0 stays zero");
  endtask

  task automatic t_neg_offset();
    do_store(10, 1, 16'hFFFC, 32'd196, 32'h1234_5678, "R5 R8 negative offset store data");
  endtask

  task automatic t_branches();
    logic [31:0] tgt;
    tgt = exp_pc + 4 + 8;
    do_beq(3, 3, 16'd2);
    @(negedge clk); clr_ctl();
    #1 chk("R6 R7 taken branch target", mem_addr, tgt);
    exp_pc = tgt;
    do_beq(1, 3, 16'd2);
    @(negedge clk); clr_ctl();
    #1 chk("R6 untaken branch keeps PC+4", mem_addr, exp_pc);
  endtask

  task automatic t_jump();
    do_jump(26'd2);
    @(negedge clk); clr_ctl();
    #1 chk("R7 jump target", mem_addr, 32'd8);
    exp_pc = 32'd8;
    do_load(0, 12, 16'd132, 32'd132);
    do_store(0, 12, 16'd180, 32'd180, 32'hFFFF_FFF0, "R8 load write-back to rt");
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    for (int i = 0; i < 64; i++) mem[i] = 32'd0;
    mem[32] = 32'h1234_5678;
    mem[33] = 32'hFFFF_FFF0;
    mem[34] = 32'd5;
    mem[35] = 32'd200;
    clr_ctl();
    rst_n = 0;
    exp_pc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_loads_stores();
    t_alu_ops();
    t_reg_zero();
    t_neg_offset();
    t_branches();
    t_jump();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule